// File: doc/BRIEF.md
# Peripheral-to-Memory DMA Channel

This block is a single transfer engine that drains a peripheral's data port into a buffer in memory. Software programs a source address, a destination address, a byte count, a pacing word (idle cycles and words per request) and a control word. Setting the top bit of the control word launches the channel. The channel then performs 32-bit read/write pairs on a simple request/ready memory bus. Each word is read from the peripheral port and written to the next destination location. The channel drops the top bit of the control word on its own once the count reaches zero. Software detects completion by polling that bit.

A burst of words begins only while the peripheral raises its request line. In the control word, one bit selects whether the source address stays fixed, as a FIFO port needs, or steps forward like the destination. Clearing the control word's top bit in the middle of a transfer stops the channel at the next word boundary. The remaining byte count stays readable after the stop.

The sequencer has five named states. IDLE waits for the run bit and leaves for ARM when it is set. ARM waits for the request line. From ARM the channel goes to FETCH when the request is high, or back to IDLE when the run bit is gone. FETCH holds a read until the bus accepts it, then moves to STORE. STORE holds the write until it is accepted. From STORE the channel goes to IDLE when the count is exhausted or the run bit was cleared. Otherwise it goes to PAUSE when idle cycles are configured, to ARM when the burst is spent, or straight back to FETCH. PAUSE counts down the idle cycles and then goes to FETCH, or to ARM at a burst end. PAUSE also goes to IDLE on a cleared run bit.

Top module: `pdma_channel`

## Requirements
- R1: After reset every register reads zero and the bus request is low.
- R2: Registers sit at byte offsets 0x00 (control), 0x04 (source), 0x08 (destination), 0x0C (count) and 0x18 (pacing); any other offset reads zero. Control bits 30:0 read back as written, including these fields: destination width at 26:25, destination request type at 20:16, source width at 10:9, fixed-source select at bit 5 and source request type at 4:0. The pacing word keeps only idle cycles in bits 3:0 and words-per-request minus one in bits 14:8; all its other bits read zero.
- R3: The two low bits of a written count are dropped and read back as zero, so the count is always a multiple of 4.
- R4: A control write with bit 31 set, made while the channel is idle and the count is nonzero, starts a transfer, and bit 31 reads 1 until the transfer ends. With a zero count, bit 31 stays 0 and the bus stays quiet.
- R5: Each word is one read of the source address followed by one write of the same data to the destination. A request holds its address, direction and data until ready is high at a clock edge.
- R6: After each accepted write, the destination and the readable destination register rise by 4 and the count falls by 4. The source rises by 4 when bit 5 is 0 and stays put when bit 5 is 1.
- R7: Each burst moves (pacing bits 14:8)+1 words, and the first read of a burst is issued only if the peripheral request was high in the preceding cycle.
- R8: Between an accepted write and the next read of the same burst there are exactly N idle cycles, where N is pacing bits 3:0. At a burst boundary, with the request held high, there are exactly N+1.
- R9: In the cycle after the final write is accepted, control bit 31 reads 0 and the bus is idle. The source, destination and count registers then show the final values.
- R10: Writing the control word with bit 31 clear during a transfer ends it after the word in flight. No further read is issued, and the count register shows the bytes not moved.
- R11: While a transfer is active, writes to the source, destination, count and pacing registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| periph_req | input | 1 | Peripheral data-ready request |
| bus_req | output | 1 | Memory bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Memory bus byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready on a read |
| bus_ready | input | 1 | Bus accepts the current request at this edge |

## Verification
The assertions watch, on every cycle, that a stalled request stays stable, and that each accepted write steps the destination and count by one word. They also check that the count never loses its word alignment, that a burst never starts without a prior peripheral request, and that the final write drops the run bit and leaves the bus quiet. Some behaviour can only be shown by the bench's scenarios, run against its own transfer model. This covers data flowing from the source read into the matching write, and exact idle-cycle spacing with the fixed and stepping source modes. It also covers the ignoring of register writes mid-transfer, a zero-count start, and an abort landing on a word boundary with the right residual count.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_FETCH,
        ST_STORE,
        ST_PAUSE
    } pdma_state_e;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_SRC  = 8'h04;
    localparam logic [7:0] OFS_DST  = 8'h08;
    localparam logic [7:0] OFS_CNT  = 8'h0C;
    localparam logic [7:0] OFS_PACE = 8'h18;

    localparam int CTRL_RUN_BIT   = 31;
    localparam int CTRL_FIXED_BIT = 5;
    localparam int PACE_BLK_LSB   = 8;
    localparam int PACE_WAIT_LSB  = 0;

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WAIT_W = 4,
    parameter int BLK_W  = 7,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              active,
    input  logic              step,
    output logic              run,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [ADDR_W-1:0] byte_cnt,
    output logic [WAIT_W-1:0] wait_cyc,
    output logic [BLK_W-1:0]  blk_len
);

    localparam int STEP = DATA_W / 8;
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
    localparam logic [ADDR_W-1:0] CNT_MASK = ~(ADDR_W'(STEP - 1));

    logic [DATA_W-2:0] ctrl_q;
    logic              run_q;
    logic [ADDR_W-1:0] src_q, dst_q, cnt_q;
    logic [WAIT_W-1:0] wait_q;
    logic [BLK_W-1:0]  blk_q;
    logic              locked;

    assign locked = run_q | active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            run_q  <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            wait_q <= '0;
            blk_q  <= '0;
        end else begin
            if (step) begin
                dst_q <= dst_q + STEP_V;
                cnt_q <= cnt_q - STEP_V;
                if (!ctrl_q[CTRL_FIXED_BIT]) begin
                    src_q <= src_q + STEP_V;
                end
                if (cnt_q == STEP_V) begin
                    run_q <= 1'b0;
                end
            end
            if (reg_we) begin
                if (reg_addr == REG_AW'(OFS_CTRL)) begin
                    if (!locked) begin
                        ctrl_q <= reg_wdata[DATA_W-2:0];
                        run_q  <= reg_wdata[CTRL_RUN_BIT] && (cnt_q != '0);
                    end else if (!reg_wdata[CTRL_RUN_BIT]) begin
                        run_q <= 1'b0;
                    end
                end else if (!locked) begin
                    if (reg_addr == REG_AW'(OFS_SRC)) begin
                        src_q <= reg_wdata[ADDR_W-1:0];
                    end else if (reg_addr == REG_AW'(OFS_DST)) begin
                        dst_q <= reg_wdata[ADDR_W-1:0];
                    end else if (reg_addr == REG_AW'(OFS_CNT)) begin
                        cnt_q <= reg_wdata[ADDR_W-1:0] & CNT_MASK;
                    end else if (reg_addr == REG_AW'(OFS_PACE)) begin
                        wait_q <= reg_wdata[PACE_WAIT_LSB +: WAIT_W];
                        blk_q  <= reg_wdata[PACE_BLK_LSB +: BLK_W];
                    end
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFS_CTRL)) begin
            reg_rdata = {run_q, ctrl_q};
        end else if (reg_addr == REG_AW'(OFS_SRC)) begin
            reg_rdata = DATA_W'(src_q);
        end else if (reg_addr == REG_AW'(OFS_DST)) begin
            reg_rdata = DATA_W'(dst_q);
        end else if (reg_addr == REG_AW'(OFS_CNT)) begin
            reg_rdata = DATA_W'(cnt_q);
        end else if (reg_addr == REG_AW'(OFS_PACE)) begin
            reg_rdata[PACE_WAIT_LSB +: WAIT_W] = wait_q;
            reg_rdata[PACE_BLK_LSB +: BLK_W]   = blk_q;
        end
    end

    assign run      = run_q;
    assign src_addr = src_q;
    assign dst_addr = dst_q;
    assign byte_cnt = cnt_q;
    assign wait_cyc = wait_q;
    assign blk_len  = blk_q;

endmodule

// File: rtl/pdma_fsm.sv
module pdma_fsm
    import pdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WAIT_W = 4,
    parameter int BLK_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              last_word,
    input  logic              periph_req,
    input  logic [WAIT_W-1:0] wait_cyc,
    input  logic [BLK_W-1:0]  blk_len,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              step,
    output logic              active,
    output pdma_state_e       state
);

    localparam int BEAT_W = BLK_W + 1;

    pdma_state_e       state_q, state_d;
    logic [BEAT_W-1:0] beats_q;
    logic [WAIT_W-1:0] gap_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (!run)            state_d = ST_IDLE;
                else if (periph_req) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (bus_ready) state_d = ST_STORE;
            end
            ST_STORE: begin
                if (bus_ready) begin
                    if (last_word || !run)       state_d = ST_IDLE;
                    else if (wait_cyc != '0)     state_d = ST_PAUSE;
                    else if (beats_q == BEAT_W'(1)) state_d = ST_ARM;
                    else                         state_d = ST_FETCH;
                end
            end
            ST_PAUSE: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (gap_q == WAIT_W'(1)) begin
                    state_d = (beats_q == '0) ? ST_ARM : ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q <= '0;
            gap_q   <= '0;
            data_q  <= '0;
        end else begin
            if (state_q == ST_ARM && state_d == ST_FETCH) begin
                beats_q <= BEAT_W'(blk_len) + BEAT_W'(1);
            end else if (state_q == ST_STORE && bus_ready) begin
                beats_q <= beats_q - BEAT_W'(1);
            end
            if (state_q == ST_STORE && bus_ready) begin
                gap_q <= wait_cyc;
            end else if (state_q == ST_PAUSE) begin
                gap_q <= gap_q - WAIT_W'(1);
            end
            if (state_q == ST_FETCH && bus_ready) begin
                data_q <= bus_rdata;
            end
        end
    end

    always_comb begin
        bus_req = 1'b0;
        bus_we  = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                bus_req = 1'b1;
            end
            ST_STORE: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
                step    = bus_ready;
            end
            default: begin
                bus_req = 1'b0;
            end
        endcase
    end

    assign bus_wdata = data_q;
    assign active    = (state_q != ST_IDLE);
    assign state     = state_q;

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WAIT_W = 4,
    parameter int BLK_W  = 7,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              periph_req,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(DATA_W / 8);

    logic              run_w, step_w, active_w, last_w;
    logic [ADDR_W-1:0] src_w, dst_w, cnt_w;
    logic [WAIT_W-1:0] wait_w;
    logic [BLK_W-1:0]  blk_w;
    pdma_state_e       state_w;

    pdma_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W),
        .BLK_W(BLK_W), .REG_AW(REG_AW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .active   (active_w),
        .step     (step_w),
        .run      (run_w),
        .src_addr (src_w),
        .dst_addr (dst_w),
        .byte_cnt (cnt_w),
        .wait_cyc (wait_w),
        .blk_len  (blk_w)
    );

    assign last_w = (cnt_w == STEP_V);

    pdma_fsm #(
        .DATA_W(DATA_W), .WAIT_W(WAIT_W), .BLK_W(BLK_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .last_word (last_w),
        .periph_req(periph_req),
        .wait_cyc  (wait_w),
        .blk_len   (blk_w),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .step      (step_w),
        .active    (active_w),
        .state     (state_w)
    );

    assign bus_addr = bus_we ? dst_w : src_w;

endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              periph_req,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic              run,
    input logic [ADDR_W-1:0] cnt,
    input logic [ADDR_W-1:0] dst,
    input pdma_state_e       state
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(DATA_W / 8);

    a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    a_r6_dst_steps: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_ready |=> dst == $past(dst) + STEP_V);

    a_r6_cnt_steps: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_ready |=> cnt == $past(cnt) - STEP_V);

    a_r3_cnt_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[1:0] == 2'b00);

    a_r7_burst_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && $past(state) == ST_ARM) |-> $past(periph_req));

    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_ready && cnt == STEP_V |=> !run && !bus_req);

endmodule

bind pdma_channel pdma_channel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .periph_req(periph_req),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .run       (run_w),
    .cnt       (cnt_w),
    .dst       (dst_w),
    .state     (state_w)
);

// File: tb/pdma_channel_tb_top.sv
module pdma_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b0;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b1;

    int checks = 0;
    int errors = 0;

    pdma_channel dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Environment controls and transfer model
    bit          stall_on = 0;
    bit          drq_rand = 0;
    bit          drq_force = 0;
    int          pops = 0;
    logic [15:0] lfsr = 16'hACE1;

    bit          m_track = 0, m_strict = 0, m_fixed = 0, m_aborted = 0;
    bit          m_seen_wr = 0, m_done_chk = 0;
    bit          m_prev_req = 0, m_prev_we = 0, m_prev_drq = 0;
    logic [31:0] m_src, m_dst, m_cnt, m_rd;
    int          m_wait = 0, m_blk = 0, m_pos = 0, m_idle = 0;
    int          m_reads = 0, m_writes = 0;

    // Memory responder and request-line driver, updated just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_ready = stall_on ? (lfsr[0] | lfsr[3]) : 1'b1;
            bus_rdata = 32'hC0DE_0000 + 32'(pops);
            periph_req = drq_rand ? (lfsr[5] & lfsr[9]) : drq_force;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && m_track) begin
            if (m_done_chk) begin
                m_done_chk = 0;
                chk(!bus_req, "R9 bus idle after last word", 32'(bus_req), 32'h0);
                if (reg_addr == 8'h00)
                    chk(reg_rdata[31] == 1'b0, "R9 run bit cleared", 32'(reg_rdata[31]), 32'h0);
            end else if (!m_aborted && m_cnt != 0 && reg_addr == 8'h00) begin
                chk(reg_rdata[31] == 1'b1, "R4 run bit held while busy", 32'(reg_rdata[31]), 32'h1);
            end
            if (bus_req && !bus_we) begin
                if (!(m_prev_req && !m_prev_we)) begin
                    chk(bus_addr == m_src, "R6 source address", bus_addr, m_src);
                    if (m_pos == 0)
                        chk(m_prev_drq, "R7 burst start without request", 32'(m_prev_drq), 32'h1);
                    if (m_seen_wr && (m_pos != 0 || m_strict))
                        chk(m_idle == ((m_pos == 0) ? m_wait + 1 : m_wait), "R8 idle cycles",
                            32'(m_idle), 32'((m_pos == 0) ? m_wait + 1 : m_wait));
                end
                if (bus_ready) begin
                    m_rd = bus_rdata;
                    m_reads++;
                    pops++;
                end
            end else if (bus_req && bus_we) begin
                if (!(m_prev_req && m_prev_we)) begin
                    chk(bus_addr == m_dst, "R6 destination address", bus_addr, m_dst);
                    chk(bus_wdata == m_rd, "R5 write data equals read data", bus_wdata, m_rd);
                end
                if (bus_ready) begin
                    m_dst = m_dst + 4;
                    if (!m_fixed) m_src = m_src + 4;
                    m_cnt = m_cnt - 4;
                    m_writes++;
                    m_pos = (m_pos + 1 == m_blk + 1) ? 0 : m_pos + 1;
                    m_idle = 0;
                    m_seen_wr = 1;
                    if (m_cnt == 0) m_done_chk = 1;
                end
            end else begin
                m_idle++;
            end
            m_prev_req = bus_req;
            m_prev_we  = bus_we;
        end
        m_prev_drq = periph_req;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0; reg_addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #2;
        reg_addr = 8'h00;
    endtask

    task automatic program_and_start(input logic [31:0] src, input logic [31:0] dst, input int bytes,
                                     input int wt, input int blk, input bit fixed);
        wr(8'h04, src);
        wr(8'h08, dst);
        wr(8'h0C, 32'(bytes));
        wr(8'h18, (32'(blk) << 8) | 32'(wt));
        m_src = src; m_dst = dst; m_cnt = 32'(bytes);
        m_wait = wt; m_blk = blk; m_fixed = fixed; m_pos = 0; m_idle = 0;
        m_reads = 0; m_writes = 0; m_seen_wr = 0; m_done_chk = 0; m_aborted = 0;
        m_prev_req = 0; m_prev_we = 0;
        wr(8'h00, 32'h8401_0403 | (fixed ? 32'h20 : 32'h0));
        m_track = 1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (m_cnt == 0 && !bus_req) break;
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_checks(input logic [31:0] src, input logic [31:0] dst, input int bytes, input bit fixed);
        logic [31:0] v;
        m_track = 0;
        rd(8'h00, v); chk(v[31] == 1'b0, "R9 run bit after transfer", v, {1'b0, v[30:0]});
        rd(8'h0C, v); chk(v == 32'h0, "R9 count register empty", v, 32'h0);
        rd(8'h08, v); chk(v == dst + 32'(bytes), "R6 destination register final", v, dst + 32'(bytes));
        rd(8'h04, v); chk(v == (fixed ? src : src + 32'(bytes)), "R6 source register final",
                          v, fixed ? src : src + 32'(bytes));
        chk(m_writes == bytes / 4, "R5 word count", 32'(m_writes), 32'(bytes / 4));
    endtask

    initial begin
        logic [31:0] v;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;

        // Reset state
        rd(8'h00, v); chk(v == 0, "R1 control after reset", v, 0);
        rd(8'h04, v); chk(v == 0, "R1 source after reset", v, 0);
        rd(8'h08, v); chk(v == 0, "R1 destination after reset", v, 0);
        rd(8'h0C, v); chk(v == 0, "R1 count after reset", v, 0);
        rd(8'h18, v); chk(v == 0, "R1 pacing after reset", v, 0);
        chk(!bus_req, "R1 bus idle after reset", 32'(bus_req), 0);

        // Register map and field readback
        wr(8'h00, 32'h0401_0423);
        rd(8'h00, v); chk(v == 32'h0401_0423, "R2 control fields", v, 32'h0401_0423);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, v); chk(v == 32'h0000_7F0F, "R2 pacing fields", v, 32'h0000_7F0F);
        wr(8'h04, 32'h1234_5678);
        rd(8'h04, v); chk(v == 32'h1234_5678, "R2 source register", v, 32'h1234_5678);
        rd(8'h10, v); chk(v == 0, "R2 unmapped offset", v, 0);

        // Count alignment
        wr(8'h0C, 32'h0000_0013);
        rd(8'h0C, v); chk(v == 32'h10, "R3 count low bits dropped", v, 32'h10);

        // Zero-count start has no effect
        wr(8'h0C, 32'h0);
        wr(8'h00, 32'h8401_0423);
        rd(8'h00, v); chk(v[31] == 1'b0, "R4 zero count start ignored", v, {1'b0, v[30:0]});
        drq_force = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!bus_req, "R4 no bus activity on zero count", 32'(bus_req), 0);
        end

        // Fixed source, one word per request, no idle cycles
        m_strict = 1; stall_on = 0; drq_rand = 0; drq_force = 1;
        program_and_start(32'h4000_0030, 32'h8000_0000, 32, 0, 0, 1);
        wait_done();
        finish_checks(32'h4000_0030, 32'h8000_0000, 32, 1);

        // Fixed source, four-word bursts, three idle cycles, stalling bus
        m_strict = 1; stall_on = 1;
        program_and_start(32'h4000_0030, 32'h8000_1000, 64, 3, 3, 1);
        wait_done();
        finish_checks(32'h4000_0030, 32'h8000_1000, 64, 1);

        // Stepping source, two-word bursts, sparse request line
        m_strict = 0; stall_on = 1; drq_rand = 1;
        program_and_start(32'h2000_0000, 32'h8000_2000, 48, 1, 1, 0);
        wait_done();
        finish_checks(32'h2000_0000, 32'h8000_2000, 48, 0);

        // Register writes ignored mid-transfer
        m_strict = 1; stall_on = 0; drq_rand = 0; drq_force = 1;
        program_and_start(32'h4000_0030, 32'h8000_3000, 96, 2, 2, 1);
        while (m_writes < 3) @(negedge clk);
        wr(8'h18, 32'h0);
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h4);
        wr(8'h04, 32'h0);
        wait_done();
        finish_checks(32'h4000_0030, 32'h8000_3000, 96, 1);
        rd(8'h18, v); chk(v == 32'h0000_0202, "R11 pacing unchanged", v, 32'h0000_0202);

        // Abort at a word boundary
        m_strict = 1; stall_on = 1;
        program_and_start(32'h4000_0030, 32'h8000_4000, 400, 1, 7, 1);
        while (m_writes < 5) @(negedge clk);
        m_aborted = 1;
        wr(8'h00, 32'h0);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(!bus_req, "R10 bus idle after abort", 32'(bus_req), 0);
        chk(m_reads == m_writes, "R10 no read after abort", 32'(m_reads), 32'(m_writes));
        chk(m_writes < 100, "R10 transfer stopped early", 32'(m_writes), 32'd99);
        m_track = 0;
        rd(8'h0C, v); chk(v == 32'(400 - 4 * m_writes), "R10 residual count", v, 32'(400 - 4 * m_writes));
        rd(8'h00, v); chk(v[31] == 1'b0, "R10 run bit clear", v, {1'b0, v[30:0]});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule